// File: doc/BRIEF.md
# Write-Through Store Buffer with Read Bypass

This block sits between a write-through cache and the next memory level. Each processor store is placed in a small queue and the block returns at once, so a burst of stores does not hold up the core. The queue then empties itself toward memory in the background, oldest entry first, whenever the memory port is free.

A read that missed in the cache enters through a separate request port. Before that read goes out, its address is compared with every live entry in the queue, which catches a load that depends on a store that has not yet left. Two parameters set the policy. `ORDER` selects whether a read without a match may overtake queued stores, or whether the queue must empty first. `ON_HIT` selects whether a matching read is answered from the youngest queued copy, or waits until the matching stores have left. One memory port carries both the queued stores and the reads. A read that is cleared to go always wins that port.

Top module: `wtbuf_top`

## Requirements
- R1: A store offered while the queue is not full is accepted in the same cycle (`wr_ready` high). It later appears on the memory port as a write (`mem_req_write`=1) with the same address and data.
- R2: Queued stores leave on the memory port in the order they were accepted.
- R3: The queue holds `DEPTH` stores. While it is full, `wr_ready` is low, the offered store is held back, and it is taken once a slot frees.
- R4: In bypass order (`ORDER`=ORD_BYPASS), a read whose address matches no queued store goes to memory before the stores that are already waiting. Its reply carries the memory data.
- R5: When a read is cleared to go, the memory port carries it (`mem_req_write`=0) rather than a store. A read request that memory has not accepted stays asserted with a stable address.
- R6: In bypass order with forwarding (`ON_HIT`=HIT_FORWARD), a read that matches queued stores is answered with the data of the youngest matching store. No memory read is made for it.
- R7: In bypass order with stalling (`ON_HIT`=HIT_STALL), a matching read waits until no queued store matches. It then goes out ahead of the remaining unrelated stores and returns the data just written.
- R8: In drain order (`ORDER`=ORD_DRAIN), a read goes to memory only once the queue is empty.
- R9: One read is in flight at a time. `rd_ready` is low from acceptance until the reply. The reply is a one-cycle `rd_resp_valid` pulse, which comes one cycle after `mem_resp_valid` for memory reads.
- R10: After reset the queue is empty, `wr_ready` and `rd_ready` are high, and `mem_req_valid` and `rd_resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Processor store offered |
| wr_ready | output | 1 | Store accepted this cycle |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| rd_valid | input | 1 | Read-miss request offered |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_addr | input | AW | Read-miss address |
| rd_resp_valid | output | 1 | Read reply pulse |
| rd_resp_data | output | DW | Read reply data |
| mem_req_valid | output | 1 | Memory transaction offered |
| mem_req_ready | input | 1 | Memory accepts the transaction |
| mem_req_write | output | 1 | 1 for a store drain, 0 for a read |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Store data for a drain (zero for reads) |
| mem_resp_valid | input | 1 | Memory read data returned |
| mem_resp_data | input | DW | Memory read data |

## Verification
Three builds are driven, one for each policy combination. Each read is aimed either at an address with no queued store, at an address stored more than once, or at an address whose store sits at the head of a blocked queue. The no-match read shows whether a read overtakes waiting stores. The repeated address shows whether the youngest copy is returned. The blocked head shows whether a matching read stalls and then passes the unrelated store behind it. Bursts against a memory port held not-ready cover the full-queue stall and the drain order. The log of memory transactions in each case tells the three read policies apart.

// File: rtl/wtbuf_pkg.sv
package wtbuf_pkg;

    // Read-control sequencer states
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_CHECK = 2'd1,
        RD_ISSUE = 2'd2,
        RD_RESP  = 2'd3
    } rd_state_e;

    // Whether a read with no match may overtake queued stores
    typedef enum logic {
        ORD_BYPASS = 1'b0,
        ORD_DRAIN  = 1'b1
    } ord_pol_e;

    // What a matching read does in bypass order
    typedef enum logic {
        HIT_FORWARD = 1'b0,
        HIT_STALL   = 1'b1
    } hit_pol_e;

endpackage

// File: rtl/wtbuf_store.sv
module wtbuf_store #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [AW-1:0]    push_addr,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    input  logic [AW-1:0]    look_addr,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic [AW-1:0]    head_addr,
    output logic [DW-1:0]    head_data,
    output logic             hit,
    output logic [DW-1:0]    hit_data
);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [DEPTH-1:0] slot_match;
    logic [PTR_W-1:0] age_idx;

    // Per-slot address comparators
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign slot_match[g] = st_q.ent[g].vld && (st_q.ent[g].addr == look_addr);
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.ent[st_q.wp] = '{vld: 1'b1, addr: push_addr, data: push_data};
            st_d.wp           = st_q.wp + PTR_W'(1);
        end
        if (pop) begin
            st_d.ent[st_q.rp].vld = 1'b0;
            st_d.rp               = st_q.rp + PTR_W'(1);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    // Youngest match: walk from oldest to newest, the last hit wins
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        age_idx  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            age_idx = st_q.rp + PTR_W'(i);
            if (slot_match[age_idx]) begin
                hit      = 1'b1;
                hit_data = st_q.ent[age_idx].data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count     = st_q.cnt;
    assign full      = (st_q.cnt == CNT_W'(DEPTH));
    assign empty     = (st_q.cnt == '0);
    assign head_addr = st_q.ent[st_q.rp].addr;
    assign head_data = st_q.ent[st_q.rp].data;

endmodule

// File: rtl/wtbuf_rdctl.sv
module wtbuf_rdctl
    import wtbuf_pkg::*;
#(
    parameter int       AW     = 16,
    parameter int       DW     = 32,
    parameter ord_pol_e ORDER  = ORD_BYPASS,
    parameter hit_pol_e ON_HIT = HIT_FORWARD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ready,
    output logic [AW-1:0] look_addr,
    input  logic          buf_hit,
    input  logic [DW-1:0] buf_hit_data,
    input  logic          buf_empty,
    output logic          issue,
    output logic [AW-1:0] issue_addr,
    input  logic          issue_ack,
    input  logic          mem_resp_valid,
    input  logic [DW-1:0] mem_resp_data,
    output logic          resp_valid,
    output logic [DW-1:0] resp_data
);

    typedef struct packed {
        rd_state_e     state;
        logic [AW-1:0] addr;
        logic          resp_v;
        logic [DW-1:0] resp_d;
    } st_t;

    st_t  st_d, st_q;
    logic clear;
    logic fwd;

    // Policy decision for a pending read
    always_comb begin
        if (ORDER == ORD_DRAIN) begin
            clear = buf_empty;
            fwd   = 1'b0;
        end else begin
            clear = !buf_hit;
            fwd   = (ON_HIT == HIT_FORWARD) && buf_hit;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.resp_v = 1'b0;
        issue       = 1'b0;
        unique case (st_q.state)
            RD_IDLE: begin
                if (rd_valid) begin
                    st_d.addr  = rd_addr;
                    st_d.state = RD_CHECK;
                end
            end
            RD_CHECK: begin
                if (fwd) begin
                    st_d.resp_v = 1'b1;
                    st_d.resp_d = buf_hit_data;
                    st_d.state  = RD_IDLE;
                end else if (clear) begin
                    issue      = 1'b1;
                    st_d.state = issue_ack ? RD_RESP : RD_ISSUE;
                end
            end
            RD_ISSUE: begin
                issue = 1'b1;
                if (issue_ack) st_d.state = RD_RESP;
            end
            RD_RESP: begin
                if (mem_resp_valid) begin
                    st_d.resp_v = 1'b1;
                    st_d.resp_d = mem_resp_data;
                    st_d.state  = RD_IDLE;
                end
            end
            default: st_d.state = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: RD_IDLE, addr: '0, resp_v: 1'b0, resp_d: '0};
        else        st_q <= st_d;
    end

    assign rd_ready   = (st_q.state == RD_IDLE);
    assign look_addr  = st_q.addr;
    assign issue_addr = st_q.addr;
    assign resp_valid = st_q.resp_v;
    assign resp_data  = st_q.resp_d;

endmodule

// File: rtl/wtbuf_arb.sv
module wtbuf_arb #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          rd_issue,
    input  logic [AW-1:0] rd_issue_addr,
    input  logic          buf_empty,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          mem_req_ready,
    output logic          mem_req_valid,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    output logic          rd_ack,
    output logic          buf_pop
);

    // Fixed priority: a cleared read first, else the oldest store
    always_comb begin
        mem_req_valid = rd_issue || !buf_empty;
        mem_req_write = !rd_issue && !buf_empty;
        mem_req_addr  = rd_issue ? rd_issue_addr : head_addr;
        mem_req_wdata = rd_issue ? '0 : head_data;
        rd_ack        = rd_issue && mem_req_ready;
        buf_pop       = mem_req_write && mem_req_ready;
    end

endmodule

// File: rtl/wtbuf_top.sv
module wtbuf_top
    import wtbuf_pkg::*;
#(
    parameter int       AW     = 16,
    parameter int       DW     = 32,
    parameter int       DEPTH  = 4,
    parameter ord_pol_e ORDER  = ORD_BYPASS,
    parameter hit_pol_e ON_HIT = HIT_FORWARD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_resp_valid,
    output logic [DW-1:0] rd_resp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_resp_valid,
    input  logic [DW-1:0] mem_resp_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    logic             buf_full;
    logic             buf_empty;
    logic [CNT_W-1:0] buf_count;
    logic [AW-1:0]    head_addr;
    logic [DW-1:0]    head_data;
    logic             buf_hit;
    logic [DW-1:0]    hit_data;
    logic [AW-1:0]    look_addr;
    logic             buf_push;
    logic             buf_pop;
    logic             rd_issue;
    logic [AW-1:0]    rd_issue_addr;
    logic             rd_ack;

    assign wr_ready = !buf_full;
    assign buf_push = wr_valid && !buf_full;

    wtbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (buf_push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (buf_pop),
        .look_addr (look_addr),
        .full      (buf_full),
        .empty     (buf_empty),
        .count     (buf_count),
        .head_addr (head_addr),
        .head_data (head_data),
        .hit       (buf_hit),
        .hit_data  (hit_data)
    );

    wtbuf_rdctl #(.AW(AW), .DW(DW), .ORDER(ORDER), .ON_HIT(ON_HIT)) u_rdctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_valid       (rd_valid),
        .rd_addr        (rd_addr),
        .rd_ready       (rd_ready),
        .look_addr      (look_addr),
        .buf_hit        (buf_hit),
        .buf_hit_data   (hit_data),
        .buf_empty      (buf_empty),
        .issue          (rd_issue),
        .issue_addr     (rd_issue_addr),
        .issue_ack      (rd_ack),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data),
        .resp_valid     (rd_resp_valid),
        .resp_data      (rd_resp_data)
    );

    wtbuf_arb #(.AW(AW), .DW(DW)) u_arb (
        .rd_issue      (rd_issue),
        .rd_issue_addr (rd_issue_addr),
        .buf_empty     (buf_empty),
        .head_addr     (head_addr),
        .head_data     (head_data),
        .mem_req_ready (mem_req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .rd_ack        (rd_ack),
        .buf_pop       (buf_pop)
    );

endmodule

// File: rtl/wtbuf_chk.sv
module wtbuf_chk
    import wtbuf_pkg::*;
#(
    parameter int       AW     = 16,
    parameter int       DEPTH  = 4,
    parameter ord_pol_e ORDER  = ORD_BYPASS,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = PTR_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_ready,
    input logic             rd_ready,
    input logic             rd_resp_valid,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic             mem_req_write,
    input logic [AW-1:0]    mem_req_addr,
    input logic [CNT_W-1:0] buf_count,
    input logic             buf_hit,
    input logic             rd_issue
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        buf_count <= CNT_W'(DEPTH)); // R3

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_count == CNT_W'(DEPTH)) |-> !wr_ready); // R3

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |-> (mem_req_valid && !mem_req_write)); // R5

    AST_RD_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write && !mem_req_ready)
        |=> (mem_req_valid && !mem_req_write && $stable(mem_req_addr))); // R5

    AST_BYPASS_NO_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
        ((ORDER == ORD_BYPASS) && rd_issue && !$past(rd_issue)) |-> !buf_hit); // R4

    AST_DRAIN_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ((ORDER == ORD_DRAIN) && rd_issue && !$past(rd_issue)) |-> (buf_count == '0)); // R8

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_resp_valid |=> !rd_resp_valid); // R9

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |-> !rd_ready); // R9

endmodule

bind wtbuf_top wtbuf_chk #(
    .AW    (AW),
    .DEPTH (DEPTH),
    .ORDER (ORDER)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ready      (wr_ready),
    .rd_ready      (rd_ready),
    .rd_resp_valid (rd_resp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .buf_count     (buf_count),
    .buf_hit       (buf_hit),
    .rd_issue      (rd_issue)
);

// File: tb/wtbuf_top_tb.sv
`timescale 1ns/1ps
module wtbuf_top_tb;
    import wtbuf_pkg::*;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NDUT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          wr_valid       [NDUT];
    logic          wr_ready       [NDUT];
    logic [AW-1:0] wr_addr        [NDUT];
    logic [DW-1:0] wr_data        [NDUT];
    logic          rd_valid       [NDUT];
    logic          rd_ready       [NDUT];
    logic [AW-1:0] rd_addr        [NDUT];
    logic          rd_resp_valid  [NDUT];
    logic [DW-1:0] rd_resp_data   [NDUT];
    logic          mem_req_valid  [NDUT];
    logic          mem_req_ready  [NDUT];
    logic          mem_req_write  [NDUT];
    logic [AW-1:0] mem_req_addr   [NDUT];
    logic [DW-1:0] mem_req_wdata  [NDUT];
    logic          mem_resp_valid [NDUT];
    logic [DW-1:0] mem_resp_data  [NDUT];

    // Memory model and transaction log, one per build
    logic [DW-1:0] mem      [NDUT][256];
    logic          log_wr   [NDUT][64];
    logic [AW-1:0] log_addr [NDUT][64];
    logic [DW-1:0] log_data [NDUT][64];
    int            log_n    [NDUT];

    int n_tests = 0;
    int n_fail  = 0;

    // 0: bypass + forward, 1: bypass + stall, 2: drain first
    wtbuf_top #(.AW(AW), .DW(DW), .DEPTH(4), .ORDER(ORD_BYPASS), .ON_HIT(HIT_FORWARD)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid[0]), .wr_ready(wr_ready[0]), .wr_addr(wr_addr[0]), .wr_data(wr_data[0]),
        .rd_valid(rd_valid[0]), .rd_ready(rd_ready[0]), .rd_addr(rd_addr[0]),
        .rd_resp_valid(rd_resp_valid[0]), .rd_resp_data(rd_resp_data[0]),
        .mem_req_valid(mem_req_valid[0]), .mem_req_ready(mem_req_ready[0]),
        .mem_req_write(mem_req_write[0]), .mem_req_addr(mem_req_addr[0]),
        .mem_req_wdata(mem_req_wdata[0]), .mem_resp_valid(mem_resp_valid[0]),
        .mem_resp_data(mem_resp_data[0]));

    wtbuf_top #(.AW(AW), .DW(DW), .DEPTH(4), .ORDER(ORD_BYPASS), .ON_HIT(HIT_STALL)) u_dut_stall (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid[1]), .wr_ready(wr_ready[1]), .wr_addr(wr_addr[1]), .wr_data(wr_data[1]),
        .rd_valid(rd_valid[1]), .rd_ready(rd_ready[1]), .rd_addr(rd_addr[1]),
        .rd_resp_valid(rd_resp_valid[1]), .rd_resp_data(rd_resp_data[1]),
        .mem_req_valid(mem_req_valid[1]), .mem_req_ready(mem_req_ready[1]),
        .mem_req_write(mem_req_write[1]), .mem_req_addr(mem_req_addr[1]),
        .mem_req_wdata(mem_req_wdata[1]), .mem_resp_valid(mem_resp_valid[1]),
        .mem_resp_data(mem_resp_data[1]));

    wtbuf_top #(.AW(AW), .DW(DW), .DEPTH(4), .ORDER(ORD_DRAIN), .ON_HIT(HIT_FORWARD)) u_dut_drain (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid[2]), .wr_ready(wr_ready[2]), .wr_addr(wr_addr[2]), .wr_data(wr_data[2]),
        .rd_valid(rd_valid[2]), .rd_ready(rd_ready[2]), .rd_addr(rd_addr[2]),
        .rd_resp_valid(rd_resp_valid[2]), .rd_resp_data(rd_resp_data[2]),
        .mem_req_valid(mem_req_valid[2]), .mem_req_ready(mem_req_ready[2]),
        .mem_req_write(mem_req_write[2]), .mem_req_addr(mem_req_addr[2]),
        .mem_req_wdata(mem_req_wdata[2]), .mem_resp_valid(mem_resp_valid[2]),
        .mem_resp_data(mem_resp_data[2]));

    always @(posedge clk) begin
        for (int k = 0; k < NDUT; k++) begin
            if (!rst_n) begin
                log_n[k]          <= 0;
                mem_resp_valid[k] <= 1'b0;
                mem_resp_data[k]  <= '0;
                for (int i = 0; i < 256; i++) mem[k][i] <= 32'hA000_0000 + i;
            end else begin
                mem_resp_valid[k] <= 1'b0;
                if (mem_req_valid[k] && mem_req_ready[k]) begin
                    if (log_n[k] < 64) begin
                        log_wr[k][log_n[k]]   <= mem_req_write[k];
                        log_addr[k][log_n[k]] <= mem_req_addr[k];
                        log_data[k][log_n[k]] <= mem_req_wdata[k];
                    end
                    log_n[k] <= log_n[k] + 1;
                    if (mem_req_write[k]) begin
                        mem[k][mem_req_addr[k][7:0]] <= mem_req_wdata[k];
                    end else begin
                        mem_resp_valid[k] <= 1'b1;
                        mem_resp_data[k]  <= mem[k][mem_req_addr[k][7:0]];
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_log(input string req, input int k, input int idx,
                           input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [63:0] act;
        logic [63:0] exp;
        act = {log_wr[k][idx], 15'd0, log_addr[k][idx], wr ? log_data[k][idx] : 32'd0};
        exp = {wr, 15'd0, a, wr ? d : 32'd0};
        chk(req, act, exp);
    endtask

    task automatic do_write(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            output int waited);
        logic ok;
        waited = 0;
        wr_valid[k] = 1'b1;
        wr_addr[k]  = a;
        wr_data[k]  = d;
        forever begin
            ok = wr_ready[k];
            @(negedge clk);
            if (ok) break;
            waited++;
        end
        wr_valid[k] = 1'b0;
    endtask

    task automatic do_read(input int k, input logic [AW-1:0] a);
        logic ok;
        rd_valid[k] = 1'b1;
        rd_addr[k]  = a;
        forever begin
            ok = rd_ready[k];
            @(negedge clk);
            if (ok) break;
        end
        rd_valid[k] = 1'b0;
    endtask

    task automatic wait_resp(input int k, input int max_cyc, output logic seen,
                             output logic [DW-1:0] data);
        seen = 1'b0;
        data = '0;
        for (int c = 0; c < max_cyc; c++) begin
            @(negedge clk);
            if (rd_resp_valid[k]) begin
                seen = 1'b1;
                data = rd_resp_data[k];
                break;
            end
        end
    endtask

    task automatic t_reset();
        for (int k = 0; k < NDUT; k++) begin
            chk("R10 wr_ready", 64'(wr_ready[k]), 64'd1);
            chk("R10 rd_ready", 64'(rd_ready[k]), 64'd1);
            chk("R10 mem_req_valid", 64'(mem_req_valid[k]), 64'd0);
            chk("R10 rd_resp_valid", 64'(rd_resp_valid[k]), 64'd0);
        end
    endtask

    task automatic t_burst_drain();
        int base, w;
        base = log_n[0];
        mem_req_ready[0] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            do_write(0, 16'h0200 + 16'(i), 32'h0000_00B0 + 32'(i), w);
            chk("R1 accepted without wait", 64'(w), 64'd0);
        end
        repeat (10) @(negedge clk);
        chk("R1 three drains", 64'(log_n[0] - base), 64'd3);
        for (int i = 0; i < 3; i++)
            chk_log("R2 drain order", 0, base + i, 1'b1, 16'h0200 + 16'(i), 32'h0000_00B0 + 32'(i));
    endtask

    task automatic t_full();
        int base, w;
        logic ok;
        base = log_n[0];
        mem_req_ready[0] = 1'b0;
        for (int i = 0; i < 4; i++) do_write(0, 16'h0100 + 16'(i), 32'h0000_00C0 + 32'(i), w);
        wr_valid[0] = 1'b1;
        wr_addr[0]  = 16'h0104;
        wr_data[0]  = 32'h0000_00C4;
        @(negedge clk);
        chk("R3 wr_ready low when full", 64'(wr_ready[0]), 64'd0);
        repeat (3) @(negedge clk);
        chk("R3 still held", 64'(wr_ready[0]), 64'd0);
        chk("R3 nothing left while blocked", 64'(log_n[0] - base), 64'd0);
        mem_req_ready[0] = 1'b1;
        forever begin
            ok = wr_ready[0];
            @(negedge clk);
            if (ok) break;
        end
        wr_valid[0] = 1'b0;
        repeat (12) @(negedge clk);
        chk("R3 held store taken later", 64'(log_n[0] - base), 64'd5);
        for (int i = 0; i < 5; i++)
            chk_log("R2 order after full", 0, base + i, 1'b1, 16'h0100 + 16'(i), 32'h0000_00C0 + 32'(i));
    endtask

    task automatic t_bypass();
        int base, w;
        logic seen;
        logic [DW-1:0] d;
        mem_req_ready[0] = 1'b0;
        do_write(0, 16'h0010, 32'h0000_1111, w);
        do_write(0, 16'h0011, 32'h0000_2222, w);
        base = log_n[0];
        do_read(0, 16'h0005);
        chk("R5 read on port", 64'({mem_req_valid[0], mem_req_write[0]}), 64'b10);
        chk("R5 read address", 64'(mem_req_addr[0]), 64'h0005);
        chk("R9 rd_ready low while busy", 64'(rd_ready[0]), 64'd0);
        @(negedge clk);
        chk("R5 read held", 64'({mem_req_valid[0], mem_req_write[0], mem_req_addr[0]}),
            {46'd0, 2'b10, 16'h0005});
        mem_req_ready[0] = 1'b1;
        wait_resp(0, 10, seen, d);
        chk("R4 reply seen", 64'(seen), 64'd1);
        chk("R4 reply data from memory", 64'(d), 64'hA000_0005);
        @(negedge clk);
        chk("R9 reply is one pulse", 64'(rd_resp_valid[0]), 64'd0);
        chk("R9 rd_ready back", 64'(rd_ready[0]), 64'd1);
        repeat (8) @(negedge clk);
        chk_log("R4 read overtakes", 0, base, 1'b0, 16'h0005, 32'd0);
        chk_log("R4 first store after read", 0, base + 1, 1'b1, 16'h0010, 32'h0000_1111);
        chk_log("R4 second store after read", 0, base + 2, 1'b1, 16'h0011, 32'h0000_2222);
    endtask

    task automatic t_forward();
        int base, w;
        logic seen;
        logic [DW-1:0] d;
        mem_req_ready[0] = 1'b0;
        do_write(0, 16'h0020, 32'h0000_0111, w);
        do_write(0, 16'h0021, 32'h0000_0222, w);
        do_write(0, 16'h0020, 32'h0000_0333, w);
        base = log_n[0];
        do_read(0, 16'h0020);
        wait_resp(0, 5, seen, d);
        chk("R6 forwarded while memory blocked", 64'(seen), 64'd1);
        chk("R6 youngest data", 64'(d), 64'h0000_0333);
        chk("R6 no memory read", 64'(log_n[0] - base), 64'd0);
        mem_req_ready[0] = 1'b1;
        repeat (10) @(negedge clk);
        chk("R6 only stores drained", 64'(log_n[0] - base), 64'd3);
        for (int i = 0; i < 3; i++)
            chk("R6 entry is store", 64'(log_wr[0][base + i]), 64'd1);
    endtask

    task automatic t_stall();
        int base, w;
        logic seen;
        logic [DW-1:0] d;
        mem_req_ready[1] = 1'b0;
        do_write(1, 16'h0030, 32'h0000_0777, w);
        do_write(1, 16'h0031, 32'h0000_0888, w);
        base = log_n[1];
        do_read(1, 16'h0030);
        wait_resp(1, 4, seen, d);
        chk("R7 no reply on match", 64'(seen), 64'd0);
        chk("R7 port shows store not read", 64'({mem_req_valid[1], mem_req_write[1]}), 64'b11);
        mem_req_ready[1] = 1'b1;
        wait_resp(1, 10, seen, d);
        chk("R7 reply after drain", 64'(seen), 64'd1);
        chk("R7 reply data", 64'(d), 64'h0000_0777);
        repeat (6) @(negedge clk);
        chk_log("R7 matching store first", 1, base, 1'b1, 16'h0030, 32'h0000_0777);
        chk_log("R7 read next", 1, base + 1, 1'b0, 16'h0030, 32'd0);
        chk_log("R7 unrelated store last", 1, base + 2, 1'b1, 16'h0031, 32'h0000_0888);
    endtask

    task automatic t_drain();
        int base, w;
        logic seen;
        logic [DW-1:0] d;
        mem_req_ready[2] = 1'b0;
        do_write(2, 16'h0040, 32'h0000_00AA, w);
        do_write(2, 16'h0041, 32'h0000_00BB, w);
        base = log_n[2];
        do_read(2, 16'h0050);
        repeat (3) @(negedge clk);
        chk("R8 no read before empty", 64'({mem_req_valid[2], mem_req_write[2]}), 64'b11);
        mem_req_ready[2] = 1'b1;
        wait_resp(2, 10, seen, d);
        chk("R8 reply seen", 64'(seen), 64'd1);
        chk("R8 reply data", 64'(d), 64'hA000_0050);
        repeat (4) @(negedge clk);
        chk_log("R8 store one", 2, base, 1'b1, 16'h0040, 32'h0000_00AA);
        chk_log("R8 store two", 2, base + 1, 1'b1, 16'h0041, 32'h0000_00BB);
        chk_log("R8 read last", 2, base + 2, 1'b0, 16'h0050, 32'd0);
    endtask

    initial begin
        for (int k = 0; k < NDUT; k++) begin
            wr_valid[k] = 1'b0; wr_addr[k] = '0; wr_data[k] = '0;
            rd_valid[k] = 1'b0; rd_addr[k] = '0;
            mem_req_ready[k] = 1'b0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst_drain();
        t_full();
        t_bypass();
        t_forward();
        t_stall();
        t_drain();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule